// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block is the protocol core of a serial 4096 x 8 memory that answers on a two-wire bus. Its inputs are SCL and SDA samples already retimed to the system clock. It finds bus START and STOP conditions and receives bytes on SCL rising edges. It decides which bytes to acknowledge and walks each transaction through a select byte, two address bytes and then data. One select code maps to each of three regions: main array, a 32-byte one-time page, and a control byte. Toward the storage model it issues per-byte write strobes, a commit strobe that launches programming, and read fetches. A protection unit answers each data byte with a permit input. After a commit, the block refuses all select bytes for a fixed number of clocks. A master can therefore poll with START and a select byte until it gets an acknowledge.

The state machine has eleven named states. IDLE waits for START. SEL, AHI, ALO and WDAT each receive one byte. SEL_ACK, AHI_ACK, ALO_ACK and WDAT_ACK each hold the acknowledge slot that follows the matching byte. RDAT shifts a byte out. RDAT_ACK samples the master's acknowledge.

The transitions are as follows:
- START, from any state, goes to SEL.
- STOP, from any state, goes to IDLE.
- SEL goes to SEL_ACK on a valid select, or to IDLE on an invalid one.
- SEL_ACK goes to RDAT for a read, or to AHI for a write.
- AHI goes to AHI_ACK, then to ALO.
- ALO goes to ALO_ACK, then to WDAT.
- WDAT goes to WDAT_ACK, then back to WDAT.
- RDAT goes to RDAT_ACK.
- RDAT_ACK goes back to RDAT when the master acknowledges, or to IDLE when it does not.

Top module: `i2cmem_seq`

## Requirements
- R1: A select byte is acknowledged only when bits 7..4 are 1010 and bits 3..1 are 000 (main, region code 0), 001 (page, region code 1) or 100 (control, region code 2). Any other select gets no acknowledge, and the block stays off the bus until the next START.
- R2: SDA is sampled on SCL rising edges. SDA falling while SCL is high is START, and SDA rising while SCL is high is STOP, which returns the block to IDLE. After reset the block pulls nothing, strobes nothing and is not busy.
- R3: A write carries two address bytes, high byte first. Bits 7..4 of the high byte are ignored, which gives a 12-bit address on `mem_addr_o`.
- R4: A data byte that the permit input accepts is acknowledged and strobed on `mem_wr_o` with its region, address and value. The address then advances in its low 5 bits only, wrapping inside the 32-byte row.
- R5: While `wr_ok_i` is low, data bytes get no acknowledge and no strobe, and the following STOP issues no commit.
- R6: `mem_commit_o` fires only for a STOP decoded in the bit slot right after a data-byte acknowledge, and only when at least one byte was accepted. A STOP at any other point discards the write.
- R7: After a commit, `busy_o` stays high for exactly WR_CYCLES clocks. During that time no select byte is acknowledged and no write strobe occurs.
- R8: After a read select is acknowledged, the byte at the current address is fetched and sent MSB first. The address then advances over all 12 bits in the main region, and within the 32-byte row in the page and control regions.
- R9: An acknowledge from the master in the slot after a read byte fetches and sends the next byte. No acknowledge releases SDA and returns the block to IDLE.
- R10: A read select that follows a repeated START after an address-only write gets no acknowledge unless its upper seven bits equal those of the write select.
- R11: The block only ever pulls SDA low, through the enable `sda_pull_o`. It never drives a high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA bus sample |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| mem_region_o | output | 2 | Selected region: 0 main, 1 page, 2 control |
| mem_addr_o | output | 12 | Current byte address |
| mem_wdata_o | output | 8 | Byte offered with a write strobe |
| mem_wr_o | output | 1 | One-clock write strobe for an accepted byte |
| mem_commit_o | output | 1 | One-clock strobe that launches programming |
| mem_rd_o | output | 1 | One-clock read fetch at the current address |
| mem_rdata_i | input | 8 | Read data for region and address, same cycle |
| wr_ok_i | input | 1 | Protection unit permits the pending byte write |
| busy_o | output | 1 | Internal programming cycle in progress |

## Verification
The assertions cover several rules on every clock:
- An accepted byte is always acknowledged.
- A select byte that completes while busy never reaches an acknowledge state.
- Neither a write strobe nor a commit appears while busy.
- The first bit driven after a fetch matches the fetched MSB.
- IDLE never pulls SDA.
- A commit is always followed by busy.

Only the bench scenarios can show the rest. These cover the row wrap, the 12-bit address carry, the discard of a STOP in the wrong slot, the exact busy length, the rejection of a mismatched repeated START, and the release of the bus after a read without acknowledge.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK
    } seq_state_e;

    typedef enum logic [1:0] {
        RG_MAIN = 2'd0,
        RG_PAGE = 2'd1,
        RG_CTRL = 2'd2
    } region_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    function automatic region_e region_of(logic [2:0] bits);
        case (bits)
            3'b001:  return RG_PAGE;
            3'b100:  return RG_CTRL;
            default: return RG_MAIN;
        endcase
    endfunction

    function automatic logic region_valid(logic [2:0] bits);
        return (bits == 3'b000) || (bits == 3'b001) || (bits == 3'b100);
    endfunction

endpackage

// File: rtl/i2cmem_buscond.sv
module i2cmem_buscond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i && !scl_q;
    assign scl_fall_o = !scl_i && scl_q;
    assign start_o    = scl_i && scl_q && sda_q && !sda_i;
    assign stop_o     = scl_i && scl_q && !sda_q && sda_i;

endmodule

// File: rtl/i2cmem_wrtimer.sv
module i2cmem_wrtimer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (launch_i)
            cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy_o = (cnt_q != '0);

    // R7: a launch always yields a busy window
    p_launch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> busy_o) else $error("launch without busy");

endmodule

// File: rtl/i2cmem_seq.sv
module i2cmem_seq
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int ROW_W     = 5,
    parameter int WR_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [1:0]        mem_region_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_wr_o,
    output logic              mem_commit_o,
    output logic              mem_rd_o,
    input  logic [7:0]        mem_rdata_i,
    input  logic              wr_ok_i,
    output logic              busy_o
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_rise, scl_fall, start_det, stop_det, busy;

    i2cmem_buscond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    seq_state_e        state_q;
    logic [7:0]        shreg_q;
    logic [3:0]        cnt_q;
    logic [ADDR_W-1:0] addr_q;
    region_e           region_q;
    logic              rw_q, ack_q, mack_q, wr_pend_q, rpt_q;
    logic [6:0]        prev_sel_q;

    logic rx_st, byte_done, sel_ok, wr_accept, rd_load, commit;
    logic [ADDR_W-1:0] row_inc, rd_inc;

    i2cmem_wrtimer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(commit),
        .busy_o  (busy)
    );

    assign rx_st     = (state_q == ST_SEL) || (state_q == ST_AHI) ||
                       (state_q == ST_ALO) || (state_q == ST_WDAT);
    assign byte_done = scl_fall && (cnt_q == 4'd8);
    assign sel_ok    = (shreg_q[7:4] == DEV_CODE) && region_valid(shreg_q[3:1]) && !busy &&
                       !(shreg_q[0] && rpt_q && (shreg_q[7:1] != prev_sel_q));
    assign wr_accept = (state_q == ST_WDAT) && byte_done && wr_ok_i;
    assign rd_load   = scl_fall && (((state_q == ST_SEL_ACK) && rw_q) ||
                                    ((state_q == ST_RDAT_ACK) && mack_q));
    assign commit    = stop_det && (state_q == ST_WDAT) && (cnt_q == 4'd1) && wr_pend_q;
    assign row_inc   = {addr_q[ADDR_W-1:ROW_W], addr_q[ROW_W-1:0] + ROW_W'(1)};
    assign rd_inc    = (region_q == RG_MAIN) ? addr_q + ADDR_W'(1) : row_inc;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            shreg_q    <= '0;
            cnt_q      <= '0;
            addr_q     <= '0;
            region_q   <= RG_MAIN;
            rw_q       <= 1'b0;
            ack_q      <= 1'b0;
            mack_q     <= 1'b0;
            wr_pend_q  <= 1'b0;
            rpt_q      <= 1'b0;
            prev_sel_q <= '0;
        end else if (start_det) begin
            state_q   <= ST_SEL;
            cnt_q     <= '0;
            rpt_q     <= (state_q == ST_WDAT) && !wr_pend_q;
            wr_pend_q <= 1'b0;
        end else if (stop_det) begin
            state_q   <= ST_IDLE;
            wr_pend_q <= 1'b0;
            rpt_q     <= 1'b0;
        end else begin
            if (rx_st && scl_rise) begin
                shreg_q <= {shreg_q[6:0], sda_i};
                cnt_q   <= cnt_q + 4'd1;
            end
            unique case (state_q)
                ST_IDLE: ;
                ST_SEL: if (byte_done) begin
                    cnt_q <= '0;
                    if (sel_ok) begin
                        state_q  <= ST_SEL_ACK;
                        ack_q    <= 1'b1;
                        rw_q     <= shreg_q[0];
                        region_q <= region_of(shreg_q[3:1]);
                        if (!shreg_q[0]) prev_sel_q <= shreg_q[7:1];
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_AHI: if (byte_done) begin
                    cnt_q  <= '0;
                    addr_q[ADDR_W-1:8] <= shreg_q[HI_W-1:0];
                    ack_q  <= 1'b1;
                    state_q <= ST_AHI_ACK;
                end
                ST_ALO: if (byte_done) begin
                    cnt_q  <= '0;
                    addr_q[7:0] <= shreg_q;
                    ack_q  <= 1'b1;
                    state_q <= ST_ALO_ACK;
                end
                ST_WDAT: if (byte_done) begin
                    cnt_q   <= '0;
                    ack_q   <= wr_ok_i;
                    state_q <= ST_WDAT_ACK;
                    if (wr_ok_i) begin
                        wr_pend_q <= 1'b1;
                        addr_q    <= row_inc;
                    end
                end
                ST_SEL_ACK: if (scl_fall) begin
                    cnt_q <= '0;
                    if (rw_q) begin
                        state_q <= ST_RDAT;
                        shreg_q <= mem_rdata_i;
                        addr_q  <= rd_inc;
                    end else begin
                        state_q <= ST_AHI;
                    end
                end
                ST_AHI_ACK:  if (scl_fall) state_q <= ST_ALO;
                ST_ALO_ACK:  if (scl_fall) state_q <= ST_WDAT;
                ST_WDAT_ACK: if (scl_fall) state_q <= ST_WDAT;
                ST_RDAT: if (scl_fall) begin
                    if (cnt_q == 4'd7) begin
                        cnt_q   <= '0;
                        state_q <= ST_RDAT_ACK;
                    end else begin
                        shreg_q <= {shreg_q[6:0], 1'b0};
                        cnt_q   <= cnt_q + 4'd1;
                    end
                end
                ST_RDAT_ACK: begin
                    if (scl_rise) mack_q <= !sda_i;
                    if (scl_fall) begin
                        if (mack_q) begin
                            state_q <= ST_RDAT;
                            shreg_q <= mem_rdata_i;
                            addr_q  <= rd_inc;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_pull_o = ack_q;
            ST_RDAT: sda_pull_o = !shreg_q[7];
            default: sda_pull_o = 1'b0;
        endcase
        mem_region_o = region_q;
        mem_addr_o   = addr_q;
        mem_wdata_o  = shreg_q;
        mem_wr_o     = wr_accept;
        mem_commit_o = commit;
        mem_rd_o     = rd_load;
        busy_o       = busy;
    end

    // R4: an accepted byte is acknowledged in the next slot
    p_wr_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> sda_pull_o) else $error("accepted byte not acknowledged");

    // R7: a select completing while busy never reaches acknowledge
    p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (state_q == ST_SEL) && byte_done) |=> (state_q != ST_SEL_ACK))
        else $error("select acknowledged while busy");

    // R7: no write activity while busy
    p_no_wr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!mem_wr_o && !mem_commit_o)) else $error("write while busy");

    // R8: first driven bit follows the fetched byte's MSB
    p_fetch_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> (sda_pull_o == !$past(mem_rdata_i[7]))) else $error("fetched MSB not driven");

    // R1: the idle block stays off the bus
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull_o) else $error("pull while idle");

endmodule

// File: tb/i2cmem_seq_tb_top.sv
module i2cmem_seq_tb_top;
    localparam int WRC = 400;
    localparam int H   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wr_ok = 1'b1;
    logic sda_bus;
    logic sda_pull, mem_wr, mem_commit, mem_rd, busy;
    logic [1:0]  mem_region;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    i2cmem_seq #(.WR_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .mem_region_o(mem_region), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_wr_o(mem_wr), .mem_commit_o(mem_commit),
        .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata), .wr_ok_i(wr_ok), .busy_o(busy)
    );

    // storage model: main indexed by low address byte, page, control
    logic [7:0] mm [256];
    logic [7:0] pg [32];
    logic [7:0] cr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mm[i] = 8'(i) ^ 8'h5A;
            for (int i = 0; i < 32; i++)  pg[i] = 8'hC0 + 8'(i);
            cr = 8'h3C;
        end else if (mem_wr) begin
            case (mem_region)
                2'd0: mm[mem_addr[7:0]] = mem_wdata;
                2'd1: pg[mem_addr[4:0]] = mem_wdata;
                default: cr = mem_wdata;
            endcase
        end
    end

    always_comb begin
        case (mem_region)
            2'd0: mem_rdata = mm[mem_addr[7:0]];
            2'd1: mem_rdata = pg[mem_addr[4:0]];
            default: mem_rdata = cr;
        endcase
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard
    typedef struct packed { logic commit; logic [1:0] region; logic [11:0] addr; logic [7:0] data; } ev_t;
    ev_t exp_q [$];

    task automatic push_wr(input logic [1:0] r, input logic [11:0] a, input logic [7:0] d);
        exp_q.push_back('{commit: 1'b0, region: r, addr: a, data: d});
    endtask
    task automatic push_commit();
        exp_q.push_back('{commit: 1'b1, region: 2'd0, addr: 12'd0, data: 8'd0});
    endtask

    bit counting = 1'b0;
    int busy_n = 0;

    always @(negedge clk) begin
        if (rst_n && (mem_wr || mem_commit)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, mem_commit ? "R6 unexpected commit" : "R4 unexpected write strobe", 1, 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                if (mem_commit)
                    chk(e.commit == 1'b1, "R6 commit order", 1, int'(e.commit));
                else
                    chk(!e.commit && e.region == mem_region && e.addr == mem_addr && e.data == mem_wdata,
                        "R4 write strobe", int'({mem_region, mem_addr, mem_wdata}),
                        int'({e.region, e.addr, e.data}));
            end
        end
        if (rst_n && mem_commit) begin
            counting = 1'b1;
            busy_n = 0;
        end else if (counting && busy) begin
            busy_n++;
        end else if (counting && busy_n > 0) begin
            chk(busy_n == WRC, "R7 busy length", busy_n, WRC);
            counting = 1'b0;
        end
    end

    // bus driver
    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H / 2);
        ack = !sda_bus;
        wt(H / 2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl_m = 1'b1; wt(H / 2); b[i] = sda_bus; wt(H / 2); scl_m = 1'b0;
        end
        sda_m = !mack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; sda_m = 1'b1;
    endtask

    task automatic tx(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        send_byte(b, a);
        chk(a == exp_ack, req, int'(a), int'(exp_ack));
    endtask

    task automatic rx(input bit mack, input logic [7:0] exp, input string req);
        logic [7:0] b;
        recv_byte(mack, b);
        chk(b == exp, req, int'(b), int'(exp));
    endtask

    task automatic wait_idle();
        while (busy) wt(1);
        wt(2);
    endtask

    bit finished = 1'b0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        wt(5);
        chk(!sda_pull && !busy && !mem_wr && !mem_commit, "R2 reset state",
            int'({sda_pull, busy, mem_wr, mem_commit}), 0);
        rst_n = 1'b1;
        wt(5);

        // R3/R4/R6: main write, high nibble ignored, row wrap 0x3FF -> 0x3E0
        push_wr(2'd0, 12'h3FE, 8'h11);
        push_wr(2'd0, 12'h3FF, 8'h22);
        push_wr(2'd0, 12'h3E0, 8'h33);
        push_commit();
        bus_start();
        tx(8'hA0, 1'b1, "R1 main write select ack");
        tx(8'hF3, 1'b1, "R3 high address ack");
        tx(8'hFE, 1'b1, "R3 low address ack");
        tx(8'h11, 1'b1, "R4 data ack");
        tx(8'h22, 1'b1, "R4 data ack");
        tx(8'h33, 1'b1, "R4 data ack after row wrap");
        bus_stop();
        chk(busy == 1'b1, "R7 busy after commit", int'(busy), 1);

        // R7: polling while busy gets no acknowledge
        bus_start();
        tx(8'hA0, 1'b0, "R7 select refused while busy");
        bus_stop();
        wait_idle();
        bus_start();
        tx(8'hA0, 1'b1, "R7 select accepted after busy");
        bus_stop();

        // R8/R9/R10: random read with full 12-bit carry in main
        bus_start();
        tx(8'hA0, 1'b1, "R10 dummy write select");
        tx(8'h03, 1'b1, "R3 address high");
        tx(8'hFE, 1'b1, "R3 address low");
        bus_start();
        tx(8'hA1, 1'b1, "R10 matching read select ack");
        rx(1'b1, 8'h11, "R8 read byte 0x3FE");
        rx(1'b1, 8'h22, "R9 read continues at 0x3FF");
        rx(1'b0, 8'h5A, "R8 read 0x400 after full carry");
        begin
            bit quiet = 1'b1;
            sda_m = 1'b1;
            for (int i = 0; i < 9; i++) begin
                wt(H); scl_m = 1'b1; wt(H / 2);
                if (sda_bus !== 1'b1) quiet = 1'b0;
                wt(H / 2); scl_m = 1'b0;
            end
            chk(quiet, "R9 bus released after no acknowledge", int'(quiet), 1);
            chk(sda_pull == 1'b0, "R11 no pull when released", int'(sda_pull), 0);
        end
        bus_stop();

        // R8: current-address read continues from 0x401
        bus_start();
        tx(8'hA1, 1'b1, "R8 current read select");
        rx(1'b0, 8'h5B, "R8 current read value");
        bus_stop();

        // R4: page region write wraps inside the 32-byte row
        push_wr(2'd1, 12'h01F, 8'h77);
        push_wr(2'd1, 12'h000, 8'h88);
        push_commit();
        bus_start();
        tx(8'hA2, 1'b1, "R1 page write select ack");
        tx(8'h00, 1'b1, "R3 page address high");
        tx(8'h1F, 1'b1, "R3 page address low");
        tx(8'h77, 1'b1, "R4 page data");
        tx(8'h88, 1'b1, "R4 page data wrapped");
        bus_stop();
        wait_idle();
        bus_start();
        tx(8'hA2, 1'b1, "R10 page dummy write");
        tx(8'h00, 1'b1, "R3 page address high");
        tx(8'h1F, 1'b1, "R3 page address low");
        bus_start();
        tx(8'hA3, 1'b1, "R10 page read select");
        rx(1'b1, 8'h77, "R8 page byte 31");
        rx(1'b0, 8'h88, "R8 page read wraps to 0");
        bus_stop();

        // R10: repeated START with a different region is refused
        bus_start();
        tx(8'hA0, 1'b1, "R10 main dummy write");
        tx(8'h00, 1'b1, "R3 address high");
        tx(8'h10, 1'b1, "R3 address low");
        bus_start();
        tx(8'hA3, 1'b0, "R10 mismatched read select refused");
        bus_stop();

        // R1: bad device code and undefined region
        bus_start();
        tx(8'hB0, 1'b0, "R1 wrong device code");
        bus_stop();
        bus_start();
        tx(8'hA4, 1'b0, "R1 undefined region 010");
        bus_stop();
        bus_start();
        tx(8'hA9, 1'b1, "R1 control read select");
        rx(1'b0, 8'h3C, "R1 control register read");
        bus_stop();

        // R5: permit low refuses data; no commit; memory untouched
        wr_ok = 1'b0;
        bus_start();
        tx(8'hA0, 1'b1, "R5 select ack");
        tx(8'h00, 1'b1, "R5 address high");
        tx(8'h50, 1'b1, "R5 address low");
        tx(8'h99, 1'b0, "R5 data refused");
        bus_stop();
        wt(2);
        chk(busy == 1'b0, "R5 no commit after refused data", int'(busy), 0);
        wr_ok = 1'b1;
        bus_start();
        tx(8'hA0, 1'b1, "R5 readback dummy write");
        tx(8'h00, 1'b1, "R3 address high");
        tx(8'h50, 1'b1, "R3 address low");
        bus_start();
        tx(8'hA1, 1'b1, "R5 readback select");
        rx(1'b0, 8'h0A, "R5 byte unchanged");
        bus_stop();

        // R6: STOP inside a byte discards the write
        push_wr(2'd0, 12'h060, 8'h44);
        bus_start();
        tx(8'hA0, 1'b1, "R6 select ack");
        tx(8'h00, 1'b1, "R6 address high");
        tx(8'h60, 1'b1, "R6 address low");
        tx(8'h44, 1'b1, "R6 data ack");
        send_bits(8'hFF, 3);
        bus_stop();
        wt(2);
        chk(busy == 1'b0, "R6 misplaced STOP gives no commit", int'(busy), 0);

        wt(20);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule